// File: doc/BRIEF.md
# Palette and Vertical-Scroll RAM Access Port

This block sits between a CPU-side access path and two small on-chip memories of a tile-based video controller. One memory holds colour entries and the other holds per-column vertical scroll offsets. Writes do not go straight to either memory. They are queued in a four-slot write queue, and the memories are updated from the head of the queue whenever the controller grants an access slot. The same queue carries DMA fill writes. For a fill, the data comes from the queue slot at the write pointer and not from the entry itself.

Reads are served directly. The CPU requests a read of either memory at the current access address, and the merged word is returned one cycle later. Bits that the selected memory does not store are filled from the queue slot at the write pointer. After every read the access address moves forward by a programmable step. The renderer has its own read-only lookup port into each memory.

Top module: `vsp_port`

## Requirements
- R1: While four entries are queued, `push_ready` is low and a push is ignored. Without a drain, the queue stays full.
- R2: When `drain_en` is high and the queue holds an entry, the oldest entry is applied and removed. A drain from a full queue raises `push_ready` on the next cycle. Entries are applied in push order, and the pointers wrap modulo the depth.
- R3: An entry with target code 0 writes the colour memory at index (address >> 1) mod 64. The colour memory keeps value bits 11:9, 7:5 and 3:1 (mask 0xEEE), packed as 9 bits with bits 11:9 on top.
- R4: An entry with target code 1 writes the scroll memory at index ((address >> 1) & 63), storing value bits 10:0. The write is dropped when that index is 40 or more.
- R5: Entries with target codes 2 and 3 are removed from the queue without changing either memory.
- R6: An entry with partial code 2 writes the value held in the queue slot at the write pointer at the time it is applied, not its own value.
- R7: A cycle with `rd_req` high gives `rd_valid` high on the next cycle, with `rd_data` holding the read word. Otherwise `rd_valid` is low.
- R8: A CPU read of the scroll memory (`rd_tgt`=1) at an index of 40 or more returns entry 0.
- R9: In read data, the bits outside the target mask (0xEEE for colour with `rd_tgt`=0, 0x7FF for scroll) come from the queue slot at the write pointer.
- R10: After each read, the access address increases by `autoinc`, modulo 2^17. `addr_load` sets the address to `addr_in` and takes priority over the increment. A read issued in the same cycle uses the old address.
- R11: After reset, the queue is empty (`push_ready` high), both memories and all queue slots are zero, and `rd_valid` is low.
- R12: `ren_pal_data` is the stored 9-bit colour entry at `ren_pal_idx`. `ren_vs_data` is the scroll entry at `ren_vs_idx`, or 0 when that index is 40 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Offer a write entry to the queue |
| push_ready | output | 1 | Queue has space |
| push_value | input | 16 | Entry data |
| push_addr | input | 17 | Entry byte address |
| push_tgt | input | 2 | Target code: 0 colour, 1 scroll, 2/3 other |
| push_part | input | 2 | Partial code, 2 marks a fill write |
| drain_en | input | 1 | Access slot granted: apply the head entry |
| addr_load | input | 1 | Load the access address |
| addr_in | input | 17 | New access address |
| autoinc | input | 8 | Address step applied after each read |
| rd_req | input | 1 | Read request at the access address |
| rd_tgt | input | 1 | Read target: 0 colour, 1 scroll |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Merged read word |
| ren_pal_idx | input | 6 | Renderer colour index |
| ren_pal_data | output | 9 | Renderer colour entry |
| ren_vs_idx | input | 6 | Renderer scroll index |
| ren_vs_data | output | 11 | Renderer scroll entry |

## Verification
The write path is tested with four kinds of entry. Colour writes with all bits set and with mixed bits show the bit packing. Scroll writes at indices 39 and 40, and at an address above 127, separate the drop rule from the 6-bit mask. Target codes 2 and 3 show that other targets leave both memories alone. Fill entries applied after the slot at the write pointer has been loaded with a distinct word show which data a fill takes.

The read path is tested at in-range and out-of-range scroll indices, with queue slot contents that carry high bits, so that wrap-to-zero and the dirty-bit merge cannot hide each other. Address steps of 2, 0 and 3, and a step across the top of the 17-bit address space, separate the increment arithmetic from the index extraction. A load issued together with a read shows which address that read uses.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 17;

    localparam logic [1:0] TGT_PAL   = 2'd0;
    localparam logic [1:0] TGT_VS    = 2'd1;
    localparam logic [1:0] PART_FILL = 2'd2;

    localparam logic [DATA_W-1:0] PAL_MASK = 16'h0EEE;
    localparam logic [DATA_W-1:0] VS_MASK  = 16'h07FF;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        tgt;
        logic [1:0]        part;
    } vsp_entry_t;

    // three 3-bit channels held at value bits 11:9, 7:5, 3:1
    function automatic logic [8:0] pal_pack(input logic [DATA_W-1:0] v);
        return {v[11:9], v[7:5], v[3:1]};
    endfunction

    function automatic logic [DATA_W-1:0] pal_unpack(input logic [8:0] c);
        return {4'b0000, c[8:6], 1'b0, c[5:3], 1'b0, c[2:0], 1'b0};
    endfunction

endpackage

// File: rtl/vsp_fifo.sv
module vsp_fifo
    import vsp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  vsp_entry_t        push_entry,
    output logic              push_ready,
    input  logic              pop,
    output logic              head_valid,
    output vsp_entry_t        head_entry,
    output logic [DATA_W-1:0] wslot_value
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    typedef struct packed {
        vsp_entry_t [DEPTH-1:0] slot;
        logic [PW-1:0]          rd;
        logic [PW-1:0]          wr;
        logic [PW:0]            cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic push_ok, pop_ok;

    always_comb begin
        d       = q;
        push_ok = push_valid && (q.cnt != FULL_CNT);
        pop_ok  = pop && (q.cnt != '0);
        if (push_ok) begin
            d.slot[q.wr] = push_entry;
            d.wr         = q.wr + 1'b1;
        end
        if (pop_ok) begin
            d.rd = q.rd + 1'b1;
        end
        d.cnt = q.cnt + (PW+1)'(push_ok) - (PW+1)'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign push_ready  = (q.cnt != FULL_CNT);
    assign head_valid  = (q.cnt != '0);
    assign head_entry  = q.slot[q.rd];
    assign wslot_value = q.slot[q.wr].value;

endmodule

// File: rtl/vsp_ram.sv
module vsp_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    parameter int IW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IW-1:0]    a_idx,
    output logic [WIDTH-1:0] a_data,
    input  logic [IW-1:0]    b_idx,
    output logic [WIDTH-1:0] b_data
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
    } ram_st_t;

    ram_st_t q, d;

    always_comb begin
        d = q;
        if (we && (int'(waddr) < DEPTH)) begin
            d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign a_data = (int'(a_idx) < DEPTH) ? q.mem[a_idx] : '0;
    assign b_data = (int'(b_idx) < DEPTH) ? q.mem[b_idx] : '0;

endmodule

// File: rtl/vsp_port.sv
module vsp_port
    import vsp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int PAL_DEPTH  = 64,
    parameter int VS_DEPTH   = 40,
    parameter int INC_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [15:0]       push_value,
    input  logic [16:0]       push_addr,
    input  logic [1:0]        push_tgt,
    input  logic [1:0]        push_part,
    input  logic              drain_en,
    input  logic              addr_load,
    input  logic [16:0]       addr_in,
    input  logic [INC_W-1:0]  autoinc,
    input  logic              rd_req,
    input  logic              rd_tgt,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    input  logic [5:0]        ren_pal_idx,
    output logic [8:0]        ren_pal_data,
    input  logic [5:0]        ren_vs_idx,
    output logic [10:0]       ren_vs_data
);

    localparam int PAL_IW = $clog2(PAL_DEPTH);
    localparam int VS_IW  = 6;
    localparam int VS_W   = 11;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } port_st_t;

    port_st_t q, d;

    vsp_entry_t        push_entry, head;
    logic              head_valid, pop;
    logic [DATA_W-1:0] wslot;
    logic [DATA_W-1:0] wr_val;

    logic              pal_we, vs_we;
    logic [PAL_IW-1:0] pal_widx, pal_ridx;
    logic [VS_IW-1:0]  vs_widx, vs_raw_ridx, vs_ridx;
    logic [8:0]        pal_rdata;
    logic [VS_W-1:0]   vs_rdata;
    logic [ADDR_W-1:0] acc_addr_q;

    assign push_entry = '{value: push_value, addr: push_addr, tgt: push_tgt, part: push_part};

    vsp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_entry (push_entry),
        .push_ready (push_ready),
        .pop        (pop),
        .head_valid (head_valid),
        .head_entry (head),
        .wslot_value(wslot)
    );

    // write side: head of queue into the selected memory
    always_comb begin
        pop      = drain_en && head_valid;
        wr_val   = (head.part == PART_FILL) ? wslot : head.value;
        pal_widx = PAL_IW'(head.addr >> 1);
        vs_widx  = VS_IW'(head.addr >> 1);
        pal_we   = pop && (head.tgt == TGT_PAL);
        vs_we    = pop && (head.tgt == TGT_VS) && (int'(vs_widx) < VS_DEPTH);
    end

    // read side: index from the access address, out-of-range scroll wraps to 0
    always_comb begin
        pal_ridx    = PAL_IW'(q.addr >> 1);
        vs_raw_ridx = VS_IW'(q.addr >> 1);
        vs_ridx     = (int'(vs_raw_ridx) < VS_DEPTH) ? vs_raw_ridx : '0;
    end

    vsp_ram #(.DEPTH(PAL_DEPTH), .WIDTH(9), .IW(PAL_IW)) u_pal (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (pal_we),
        .waddr  (pal_widx),
        .wdata  (pal_pack(wr_val)),
        .a_idx  (pal_ridx),
        .a_data (pal_rdata),
        .b_idx  (PAL_IW'(ren_pal_idx)),
        .b_data (ren_pal_data)
    );

    vsp_ram #(.DEPTH(VS_DEPTH), .WIDTH(VS_W), .IW(VS_IW)) u_vs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (vs_we),
        .waddr  (vs_widx),
        .wdata  (wr_val[VS_W-1:0]),
        .a_idx  (vs_ridx),
        .a_data (vs_rdata),
        .b_idx  (ren_vs_idx),
        .b_data (ren_vs_data)
    );

    always_comb begin
        d          = q;
        d.rd_valid = rd_req;
        if (rd_req) begin
            if (rd_tgt) d.rd_data = DATA_W'(vs_rdata) | (wslot & ~VS_MASK);
            else        d.rd_data = pal_unpack(pal_rdata) | (wslot & ~PAL_MASK);
            d.addr = q.addr + ADDR_W'(autoinc);
        end
        if (addr_load) begin
            d.addr = addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid   = q.rd_valid;
    assign rd_data    = q.rd_data;
    assign acc_addr_q = q.addr;

endmodule

// File: rtl/vsp_port_chk.sv
module vsp_port_chk #(
    parameter int ADDR_W   = 17,
    parameter int INC_W    = 8,
    parameter int VS_DEPTH = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_ready,
    input logic              drain_en,
    input logic              addr_load,
    input logic [ADDR_W-1:0] addr_in,
    input logic [INC_W-1:0]  autoinc,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [5:0]        ren_vs_idx,
    input logic [10:0]       ren_vs_data
);

    // R1
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ready && !drain_en) |=> !push_ready);

    // R2
    full_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ready && drain_en) |=> push_ready);

    // R7
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R7
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !addr_load) |=> (acc_addr == $past(acc_addr) + ADDR_W'($past(autoinc))));

    // R10
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (acc_addr == $past(addr_in)));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_load && !rd_req) |=> $stable(acc_addr));

    // R12
    ren_vs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ren_vs_idx) >= VS_DEPTH) |-> (ren_vs_data == '0));

endmodule

bind vsp_port vsp_port_chk #(.ADDR_W(17), .INC_W(INC_W), .VS_DEPTH(VS_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_ready (push_ready),
    .drain_en   (drain_en),
    .addr_load  (addr_load),
    .addr_in    (addr_in),
    .autoinc    (autoinc),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .acc_addr   (acc_addr_q),
    .ren_vs_idx (ren_vs_idx),
    .ren_vs_data(ren_vs_data)
);

// File: tb/tb_vsp_port.sv
`timescale 1ns/1ps
module tb_vsp_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [15:0] push_value = '0;
    logic [16:0] push_addr = '0;
    logic [1:0]  push_tgt = '0;
    logic [1:0]  push_part = '0;
    logic        drain_en = 1'b0;
    logic        addr_load = 1'b0;
    logic [16:0] addr_in = '0;
    logic [7:0]  autoinc = '0;
    logic        rd_req = 1'b0;
    logic        rd_tgt = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [5:0]  ren_pal_idx = '0;
    logic [8:0]  ren_pal_data;
    logic [5:0]  ren_vs_idx = '0;
    logic [10:0] ren_vs_data;

    always #5 clk = ~clk;

    vsp_port dut (.*);

    int n_run = 0;
    int n_fail = 0;

    // independent model of the requirements
    logic [15:0] mv [4];
    logic [16:0] ma [4];
    logic [1:0]  mt [4];
    logic [1:0]  mp [4];
    int          mrd, mwr, mcnt;
    logic [8:0]  mpal [64];
    logic [10:0] mvs [40];
    logic [16:0] maddr;

    function automatic logic [8:0] b_pack(input logic [15:0] v);
        return {v[11:9], v[7:5], v[3:1]};
    endfunction

    function automatic logic [15:0] b_exp(input logic [8:0] c);
        return {4'b0, c[8:6], 1'b0, c[5:3], 1'b0, c[2:0], 1'b0};
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [15:0] v, input logic [16:0] a,
                        input logic [1:0] t, input logic [1:0] p);
        logic acc;
        push_value = v; push_addr = a; push_tgt = t; push_part = p;
        push_valid = 1'b1;
        #1 acc = push_ready;
        @(negedge clk);
        push_valid = 1'b0;
        if (acc) begin
            mv[mwr] = v; ma[mwr] = a; mt[mwr] = t; mp[mwr] = p;
            mwr = (mwr + 1) % 4; mcnt++;
        end
    endtask

    task automatic drain1();
        logic [15:0] dv;
        int idx;
        drain_en = 1'b1;
        @(negedge clk);
        drain_en = 1'b0;
        if (mcnt > 0) begin
            dv  = (mp[mrd] == 2'd2) ? mv[mwr] : mv[mrd];
            idx = int'((ma[mrd] >> 1) & 17'd63);
            if (mt[mrd] == 2'd0) mpal[idx] = b_pack(dv);
            if (mt[mrd] == 2'd1 && idx < 40) mvs[idx] = dv[10:0];
            mrd = (mrd + 1) % 4; mcnt--;
        end
    endtask

    task automatic wr_drain(input logic [15:0] v, input logic [16:0] a,
                            input logic [1:0] t, input logic [1:0] p);
        push(v, a, t, p);
        drain1();
    endtask

    task automatic load(input logic [16:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
        maddr = a;
    endtask

    function automatic logic [15:0] exp_read(input logic tgt);
        int idx;
        idx = int'((maddr >> 1) & 17'd63);
        if (!tgt) return b_exp(mpal[idx]) | (mv[mwr] & ~16'h0EEE);
        if (idx >= 40) idx = 0;
        return {5'b0, mvs[idx]} | (mv[mwr] & ~16'h07FF);
    endfunction

    task automatic cpu_read(input logic tgt, input string tag);
        logic [15:0] e;
        e = exp_read(tgt);
        rd_req = 1'b1; rd_tgt = tgt;
        @(negedge clk);
        rd_req = 1'b0;
        chk(32'(rd_valid), 32'd1, {tag, " valid"});
        chk(32'(rd_data), 32'(e), tag);
        maddr = maddr + 17'(autoinc);
    endtask

    task automatic ren_pal(input int idx, input string tag);
        ren_pal_idx = 6'(idx);
        #1 chk(32'(ren_pal_data), 32'(mpal[idx]), tag);
    endtask

    task automatic ren_vs(input int idx, input string tag);
        ren_vs_idx = 6'(idx);
        #1 chk(32'(ren_vs_data), (idx < 40) ? 32'(mvs[idx]) : 32'd0, tag);
    endtask

    task automatic t_reset();
        chk(32'(push_ready), 32'd1, "R11 push_ready after reset");
        chk(32'(rd_valid), 32'd0, "R11 rd_valid after reset");
        ren_pal(5, "R11 colour entry zero");
        ren_vs(0, "R11 scroll entry zero");
    endtask

    task automatic t_full();
        push(16'h1111, 17'h0A, 2'd2, 2'd0);
        push(16'h2222, 17'h0C, 2'd3, 2'd0);
        push(16'h3333, 17'h0E, 2'd2, 2'd0);
        push(16'h4444, 17'h10, 2'd3, 2'd0);
        chk(32'(push_ready), 32'd0, "R1 full after four pushes");
        push(16'h7777, 17'h12, 2'd0, 2'd0);
        chk(32'(push_ready), 32'd0, "R1 still full");
        for (int i = 0; i < 5; i++) drain1();
        chk(32'(push_ready), 32'd1, "R2 space after drains");
        ren_pal(9, "R1 push while full dropped");
        ren_pal(5, "R5 target code 2 no write");
        ren_pal(6, "R5 target code 3 no write");
    endtask

    task automatic t_pal_write();
        wr_drain(16'hFFFF, 17'h0A, 2'd0, 2'd0);
        ren_pal(5, "R3 all ones packed");
        wr_drain(16'h0A52, 17'h0B, 2'd0, 2'd0);
        ren_pal(5, "R3 mixed bits odd address");
        wr_drain(16'h0EEE, 17'h8C, 2'd0, 2'd0);
        ren_pal(6, "R3 index masked to 64");
    endtask

    task automatic t_vs_write();
        wr_drain(16'h1234, 17'h06, 2'd1, 2'd0);
        ren_vs(3, "R4 scroll write idx 3");
        wr_drain(16'hFFFF, 17'd78, 2'd1, 2'd0);
        ren_vs(39, "R4 scroll write idx 39");
        wr_drain(16'h05A5, 17'h00, 2'd1, 2'd0);
        wr_drain(16'h0101, 17'h02, 2'd1, 2'd0);
        wr_drain(16'h0202, 17'h04, 2'd1, 2'd0);
        wr_drain(16'h0555, 17'd80, 2'd1, 2'd0);
        ren_vs(0, "R4 idx 40 write dropped, entry 0");
        ren_vs(8, "R4 idx 40 write dropped, entry 8");
        ren_vs(40, "R12 renderer out of range is zero");
        wr_drain(16'h0111, 17'h86, 2'd1, 2'd0);
        ren_vs(3, "R4 index masked to 6 bits");
    endtask

    task automatic t_fill();
        push(16'hC3A5, 17'h0, 2'd3, 2'd0);
        push(16'h0000, 17'h14, 2'd0, 2'd2);
        push(16'h0000, 17'h0A, 2'd1, 2'd2);
        for (int i = 0; i < 3; i++) drain1();
        ren_pal(10, "R6 colour fill from write slot");
        ren_vs(5, "R6 scroll fill from write slot");
        chk(32'(ren_vs_data == 11'h000), 32'd0, "R6 fill not own value");
    endtask

    task automatic t_read_merge();
        push(16'hF0F1, 17'h0, 2'd3, 2'd0);
        push(16'hE1E2, 17'h0, 2'd3, 2'd0);
        push(16'hD3D4, 17'h0, 2'd3, 2'd0);
        push(16'hC5C6, 17'h0, 2'd3, 2'd0);
        for (int i = 0; i < 4; i++) drain1();
        autoinc = 8'd0;
        load(17'h0A);
        cpu_read(1'b0, "R7 R9 colour read merge");
        load(17'h06);
        cpu_read(1'b1, "R9 scroll read merge");
        @(negedge clk);
        chk(32'(rd_valid), 32'd0, "R7 valid drops when idle");
    endtask

    task automatic t_vs_wrap();
        autoinc = 8'd0;
        load(17'd80);
        cpu_read(1'b1, "R8 idx 40 returns entry 0");
        load(17'h7E);
        cpu_read(1'b1, "R8 idx 63 returns entry 0");
        load(17'd78);
        cpu_read(1'b1, "R8 idx 39 in range");
        load(17'h84);
        cpu_read(1'b1, "R8 idx masked before range test");
    endtask

    task automatic t_autoinc();
        autoinc = 8'd2;
        load(17'h0);
        for (int i = 0; i < 3; i++) cpu_read(1'b1, "R10 step 2");
        autoinc = 8'd0;
        cpu_read(1'b1, "R10 step 0 first");
        cpu_read(1'b1, "R10 step 0 second");
        autoinc = 8'd3;
        load(17'h0);
        for (int i = 0; i < 4; i++) cpu_read(1'b1, "R10 odd step 3");
        autoinc = 8'd4;
        load(17'h1FFFE);
        cpu_read(1'b1, "R10 before wrap");
        cpu_read(1'b1, "R10 after 17-bit wrap");
        // load together with a read: read uses old address, load wins
        autoinc = 8'd2;
        load(17'h02);
        addr_load = 1'b1; addr_in = 17'h06;
        cpu_read(1'b1, "R10 read with load uses old address");
        addr_load = 1'b0;
        maddr = 17'h06;
        cpu_read(1'b1, "R10 load wins over step");
    endtask

    initial begin
        mrd = 0; mwr = 0; mcnt = 0; maddr = '0;
        for (int i = 0; i < 4; i++) begin mv[i] = '0; ma[i] = '0; mt[i] = '0; mp[i] = '0; end
        for (int i = 0; i < 64; i++) mpal[i] = '0;
        for (int i = 0; i < 40; i++) mvs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_pal_write();
        t_vs_write();
        t_fill();
        t_read_merge();
        t_vs_wrap();
        t_autoinc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule